// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that lets a host read and write a bank of 32 byte-wide configuration registers over a 3-wire link. The link has a serial clock, an active-low select and one data line. On chip the data line is split into an input, an output and an output-enable. Every access begins with an instruction byte that gives the direction, the number of data bytes (one to four) and a start address. The data bytes follow, and after each byte the address steps on by itself.

Register 0x00 controls the port. One of its bits picks MSB-first or LSB-first bit order, and the same bit sets the stepping direction. Another of its bits, when written as one, returns every other register to its default. A changed bit order applies from the next byte of the same access. A dedicated port-reset input aborts whatever the port is doing. The serial pins are oversampled in the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `serial_cfg_port`

## Requirements
- R1: The instruction byte has the direction in bit 7 (1 = read, 0 = write), the byte count in bits 6:5 and the start register address in bits 4:0.
- R2: Count code 00 moves one data byte, 01 moves two, 10 moves three and 11 moves four. After the last data byte, further bits with select still low form a new instruction byte.
- R3: Data in is sampled at the rising serial clock edge. Read data is launched after the falling edge. The output enable is high only during the data bytes of a read.
- R4: While select is high the output enable is low. Raising select partway through a byte discards that byte. The next select-low period starts with an instruction byte.
- R5: Bit 6 of register 0x00 selects bit order, 0 for MSB-first and 1 for LSB-first. MSB-first is in effect after reset. The order applies to the instruction byte and to the data bytes alike.
- R6: After each data byte the address decrements in MSB-first order and increments in LSB-first order, wrapping modulo 32 (0x00 to 0x1F and 0x1F to 0x00).
- R7: A register takes its new value when the last bit of its data byte arrives. A write to register 0x00 inside a multibyte access sets the bit order and the step direction for the rest of that access.
- R8: A high level on the port-reset input returns the port to the instruction phase once it goes low again. A partly received byte is never written, and that holds even when its last bit arrives in the same cycle as the reset.
- R9: Writing register 0x00 with bit 5 set returns registers 0x01 to 0x1F to their defaults. Register 0x00 takes the written byte unchanged.
- R10: After power-on reset, register 0x00 holds 0x00 and register i (1 to 31) holds (37*i + 11) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; frames an access |
| port_rst | input | 1 | Port timing reset; a high level aborts the access |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data to the host |
| sdio_oe | output | 1 | Output enable for the shared data line |
| cfg_q | output | 256 | Register bank contents, register i in bits 8i+7:8i |

## Verification
Two things can land in the same system-clock cycle: the eighth rising serial clock edge of a data byte, which writes the register, and the rising edge of the port-reset input. The bench drives port_rst high in the same instant that it raises sclk for that last bit. Both pins pass through synchronizers of equal depth, so the two events reach the core in one cycle. The result is judged at the register outputs: the target register must keep its old value. After that, a fresh instruction sent under the same select-low period must write normally. A second overlap is a register 0x00 write that flips the bit order partway through a multibyte access. The bench checks that the following bytes land at addresses stepped in the new direction, with their bits taken in the new order.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int NREG      = 32;
  localparam int DW        = 8;
  localparam int AW        = $clog2(NREG);
  localparam int BW        = $clog2(DW);
  localparam int ORDER_BIT = 6;
  localparam int SWRST_BIT = 5;
  localparam int RW_BIT    = DW - 1;
  localparam int CNT_LSB   = AW;

  typedef enum logic {PH_INSTR, PH_DATA} phase_e;

  function automatic logic [NREG*DW-1:0] default_table();
    logic [NREG*DW-1:0] t;
    t = '0;
    for (int i = 1; i < NREG; i++) begin
      t[i*DW +: DW] = DW'((37 * i + 11) % 256);
    end
    return t;
  endfunction
endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] level
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign level = st[STAGES-1];
endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
  import cfgport_pkg::*;
#(
  parameter int NR = NREG,
  parameter int DWID = DW,
  parameter int AWID = $clog2(NR),
  parameter logic [NR*DWID-1:0] DEFAULTS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AWID-1:0]    wr_addr,
  input  logic [DWID-1:0]    wr_data,
  input  logic [AWID-1:0]    rd_addr,
  output logic [DWID-1:0]    rd_data,
  output logic [NR*DWID-1:0] flat_q
);
  logic [DWID-1:0] regs [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs[0] <= '0;
      for (int k = 1; k < NR; k++) regs[k] <= DEFAULTS[k*DWID +: DWID];
    end else if (wr_en) begin
      if (wr_addr == '0) begin
        regs[0] <= wr_data;
        if (wr_data[SWRST_BIT]) begin
          for (int k = 1; k < NR; k++) regs[k] <= DEFAULTS[k*DWID +: DWID];
        end
      end else begin
        regs[wr_addr] <= wr_data;
      end
    end
  end

  assign rd_data = regs[rd_addr];

  for (genvar g = 0; g < NR; g++) begin : g_flat
    assign flat_q[g*DWID +: DWID] = regs[g];
  end

  assert_swrst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data[SWRST_BIT]) |=>
      (regs[1] == DEFAULTS[DWID +: DWID] &&
       regs[NR-1] == DEFAULTS[(NR-1)*DWID +: DWID] &&
       regs[0] == $past(wr_data)));
endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
  import cfgport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_lvl,
  input  logic          cs_n_lvl,
  input  logic          prst_lvl,
  input  logic          din,
  input  logic          lsb_first,
  input  logic [DW-1:0] rd_byte,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  output logic          sdio_o,
  output logic          sdio_oe
);
  phase_e        phase_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          rw_q;
  logic [1:0]    left_q;
  logic [AW-1:0] addr_q;
  logic          sdo_q;
  logic          oe_q;
  logic          sclk_prev;

  logic          sclk_rise, sclk_fall, active, last_bit, byte_done, lsb_eff;
  logic [DW-1:0] nxt_sh;
  logic [AW-1:0] addr_step;
  logic [BW-1:0] out_idx;

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign active    = ~cs_n_lvl & ~prst_lvl;
  assign last_bit  = (bit_q == BW'(DW - 1));
  assign byte_done = active & sclk_rise & last_bit;
  assign nxt_sh    = lsb_first ? {din, sh_q[DW-1:1]} : {sh_q[DW-2:0], din};

  assign wr_en   = byte_done && (phase_q == PH_DATA) && !rw_q;
  assign wr_addr = addr_q;
  assign wr_data = nxt_sh;
  assign rd_addr = addr_q;

  assign lsb_eff   = (wr_en && addr_q == '0) ? nxt_sh[ORDER_BIT] : lsb_first;
  assign addr_step = lsb_eff ? addr_q + 1'b1 : addr_q - 1'b1;
  assign out_idx   = lsb_first ? bit_q : BW'(DW - 1) - bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_INSTR;
      bit_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      left_q    <= '0;
      addr_q    <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_lvl;
      oe_q      <= active && (phase_q == PH_DATA) && rw_q;
      if (!active) begin
        phase_q <= PH_INSTR;
        bit_q   <= '0;
      end else if (sclk_rise) begin
        bit_q <= bit_q + 1'b1;
        sh_q  <= nxt_sh;
        if (last_bit) begin
          if (phase_q == PH_INSTR) begin
            rw_q    <= nxt_sh[RW_BIT];
            left_q  <= nxt_sh[CNT_LSB +: 2];
            addr_q  <= nxt_sh[AW-1:0];
            phase_q <= PH_DATA;
          end else begin
            addr_q <= addr_step;
            if (left_q == 2'd0) phase_q <= PH_INSTR;
            else                left_q  <= left_q - 1'b1;
          end
        end
      end else if (sclk_fall && phase_q == PH_DATA && rw_q) begin
        sdo_q <= rd_byte[out_idx];
      end
    end
  end

  assign sdio_o  = sdo_q;
  assign sdio_oe = oe_q;

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=>
      (addr_q == ($past(lsb_first) ? AW'($past(addr_q) + 1'b1) : AW'($past(addr_q) - 1'b1))));

  assert_hiz_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_lvl |=> !sdio_oe);

  assert_launch_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sclk_fall) |-> $stable(sdo_q));

  assert_bits_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_lvl |=> (bit_q == '0 && phase_q == PH_INSTR));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgport_pkg::*;
#(
  parameter int NR = NREG,
  parameter int DWID = DW,
  parameter int SYNC_STAGES = 2,
  parameter logic [NR*DWID-1:0] DEFAULTS = default_table()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               port_rst,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe,
  output logic [NR*DWID-1:0] cfg_q
);
  localparam int AWID = $clog2(NR);
  localparam int NSIG = 4;

  logic [NSIG-1:0] pins_s;
  logic            wr_en;
  logic [AWID-1:0] wr_addr, rd_addr;
  logic [DWID-1:0] wr_data, rd_byte;

  cfgport_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdio_i, port_rst, cs_n, sclk}),
    .level (pins_s)
  );

  cfgport_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_lvl  (pins_s[0]),
    .cs_n_lvl  (pins_s[1]),
    .prst_lvl  (pins_s[2]),
    .din       (pins_s[3]),
    .lsb_first (cfg_q[ORDER_BIT]),
    .rd_byte   (rd_byte),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe)
  );

  cfgport_regbank #(.NR(NR), .DWID(DWID), .DEFAULTS(DEFAULTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_byte),
    .flat_q  (cfg_q)
  );

  assert_no_write_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[2] |-> !wr_en);

  assert_no_write_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[1] |-> !wr_en);
endmodule

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, port_rst = 0, sdio_i = 0;
  wire  sdio_o, sdio_oe;
  wire  [255:0] cfg_q;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_r [32];
  logic lsb_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .port_rst(port_rst),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .cfg_q(cfg_q)
  );

  function automatic logic [7:0] dflt(int i);
    return (i == 0) ? 8'h00 : 8'((37 * i + 11) % 256);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv, string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic b);
    sdio_i = b; wait_clk(8); sclk = 1; wait_clk(8); sclk = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sbit(lsb_m ? b[i] : b[7-i]);
  endtask

  task automatic model_write(inout logic [4:0] a, input logic [7:0] d);
    if (a == 5'd0) begin
      exp_r[0] = d;
      if (d[5]) for (int k = 1; k < 32; k++) exp_r[k] = dflt(k);
      lsb_m = d[6];
    end else begin
      exp_r[a] = d;
    end
    a = lsb_m ? a + 5'd1 : a - 5'd1;
  endtask

  task automatic check_bank(string req);
    for (int k = 0; k < 32; k++) chk(req, cfg_q[k*8 +: 8], exp_r[k], $sformatf("reg %0d", k));
  endtask

  task automatic wr_bytes(logic [4:0] start, int n, logic [7:0] d [4]);
    logic [4:0] a;
    send_byte({1'b0, 2'(n - 1), start});
    a = start;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i]);
      model_write(a, d[i]);
    end
  endtask

  task automatic xfer_write(logic [4:0] start, int n, logic [7:0] d [4]);
    cs_n = 0; wait_clk(8);
    wr_bytes(start, n, d);
    wait_clk(8); cs_n = 1; wait_clk(12);
  endtask

  task automatic xfer_read(logic [4:0] start, int n, string req);
    logic [4:0] a;
    logic [7:0] got;
    cs_n = 0; wait_clk(8);
    send_byte({1'b1, 2'(n - 1), start});
    a = start;
    for (int j = 0; j < n; j++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        wait_clk(8);
        got[lsb_m ? i : 7 - i] = sdio_o;
        if (i == 3) chk("R3", 32'(sdio_oe), 1, "oe during read data");
        sclk = 1; wait_clk(8); sclk = 0;
      end
      chk(req, 32'(got), 32'(exp_r[a]), $sformatf("read addr %0d", a));
      a = lsb_m ? a + 5'd1 : a - 5'd1;
    end
    wait_clk(8); cs_n = 1; wait_clk(12);
    chk("R4", 32'(sdio_oe), 0, "oe after deselect");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    for (int k = 0; k < 32; k++) exp_r[k] = dflt(k);
    wait_clk(5); rst_n = 1; wait_clk(5);
    // R10: power-on contents
    check_bank("R10");
    chk("R4", 32'(sdio_oe), 0, "oe idle");

    // R1, R7: single-byte write to every register except 0x00, MSB-first
    for (int k = 1; k < 32; k++) begin
      d[0] = 8'(k ^ 8'hA5); d[1] = 0; d[2] = 0; d[3] = 0;
      xfer_write(5'(k), 1, d);
    end
    check_bank("R1");

    // R2, R6: counts 2..4, decrementing, MSB-first
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    xfer_write(5'd9, 4, d);
    d = '{8'h55, 8'h66, 8'h77, 8'h00};
    xfer_write(5'd20, 3, d);
    d = '{8'h88, 8'h99, 8'h00, 8'h00};
    xfer_write(5'd30, 2, d);
    check_bank("R2");
    xfer_read(5'd31, 4, "R6");
    xfer_read(5'd1, 2, "R1");

    // R5: switch to LSB-first, then increment with wrap 0x1E..0x01
    d = '{8'h40, 8'h00, 8'h00, 8'h00};
    xfer_write(5'd0, 1, d);
    chk("R5", 32'(cfg_q[7:0]), 32'h40, "order reg");
    d = '{8'hC1, 8'hC2, 8'h40, 8'hC4};
    xfer_write(5'd30, 4, d);
    check_bank("R6");
    xfer_read(5'd29, 4, "R5");

    // R7: mid-access order flip back to MSB-first, step reverses
    d = '{8'h00, 8'hE1, 8'hE2, 8'h00};
    xfer_write(5'd0, 3, d);
    check_bank("R7");
    chk("R7", 32'(lsb_m), 0, "model order after flip");

    // R2: back-to-back instructions under one select
    cs_n = 0; wait_clk(8);
    d = '{8'h3A, 0, 0, 0}; wr_bytes(5'd7, 1, d);
    d = '{8'h3B, 0, 0, 0}; wr_bytes(5'd8, 1, d);
    wait_clk(8); cs_n = 1; wait_clk(12);
    check_bank("R2");

    // R4: select rises mid-byte
    cs_n = 0; wait_clk(8);
    send_byte({1'b0, 2'd0, 5'd12});
    for (int i = 0; i < 5; i++) sbit(1'b1);
    cs_n = 1; wait_clk(12);
    check_bank("R4");
    d = '{8'h5C, 0, 0, 0};
    xfer_write(5'd12, 1, d);
    check_bank("R4");

    // R8: port reset mid-byte, then fresh instruction under same select
    cs_n = 0; wait_clk(8);
    send_byte({1'b0, 2'd0, 5'd5});
    for (int i = 0; i < 4; i++) sbit(1'b0);
    port_rst = 1; wait_clk(4); port_rst = 0; wait_clk(8);
    check_bank("R8");
    d = '{8'h3C, 0, 0, 0}; wr_bytes(5'd5, 1, d);
    wait_clk(8); cs_n = 1; wait_clk(12);
    check_bank("R8");

    // R8: port reset in the same instant as the last data bit
    cs_n = 0; wait_clk(8);
    send_byte({1'b0, 2'd0, 5'd6});
    for (int i = 0; i < 7; i++) sbit(1'b1);
    sdio_i = 1'b1; wait_clk(8);
    sclk = 1; port_rst = 1; wait_clk(8);
    sclk = 0; port_rst = 0; wait_clk(8);
    cs_n = 1; wait_clk(12);
    check_bank("R8");

    // R9: software reset keeps register 0x00 as written
    d = '{8'h20, 0, 0, 0};
    xfer_write(5'd0, 1, d);
    check_bank("R9");
    chk("R9", 32'(cfg_q[7:0]), 32'h20, "reg0 kept");
    xfer_read(5'd3, 3, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule